// File: doc/BRIEF.md
# PLL Reset and Bypass Sequencer

This controller turns a set of active-low chip reset inputs into per-PLL reset and bypass control lines for two clock domains. The always-on domain has three PLLs and the main domain has twenty-six PLL slots. The type of reset decides whether a PLL is held in reset, switched to bypass, or left running. In bypass, the PLL output carries its reference input clock.

The two power-on resets hold PLLs in reset. The always-on power-on reset covers both domains, and the main power-on reset covers only the main domain. Warm resets do not reset any PLL; they switch PLLs to bypass for as long as the warm reset is asserted:

- An ordinary warm reset, from the warm pin or the reset-request input, bypasses every always-on PLL and a compile-time subset of main PLLs.
- A thermal warm reset bypasses every PLL in both domains.

Each PLL also has a sticky bit that software can write. When a PLL's sticky bit is set, the PLL stays in bypass after the warm reset ends, until software writes the bit back to 0.

All reset inputs pass through two-flop synchronizers before they are decoded. Power-on resets assert their reset outputs asynchronously. A small register port gives access to the sticky bits and to the current bypass state.

Top module: `pll_rst_byp_ctrl`

## Requirements
- R1: While `aon_por_n` is low, every bit of `aon_pll_rst` and `main_pll_rst` is 1 (asserted without waiting for a clock), all bypass outputs are 0 and all sticky bits of both domains are 0. After `aon_por_n` rises, `aon_pll_rst` clears on the second rising clock edge.
- R2: While `main_por_n` is low, every bit of `main_pll_rst` is 1, and the main bypass outputs and main sticky bits are 0. The always-on outputs and sticky bits are unaffected. `main_pll_rst` clears on the second rising edge after both power-on resets are high.
- R3: An ordinary warm reset (`aon_warm_n` low or `req_warm_n` low) sets all three `aon_pll_byp` bits. A warm input that is low at rising edge k is seen on the bypass outputs after edge k+2.
- R4: An ordinary warm reset sets `main_pll_byp` only for main indices 0, 4, 5, 6, 7, 8, 12, 13, 14, 15, 24 and 25, which is the default mask 26'h300F1F1. Indices 1, 2, 3, 16, 17, 18, 19 and 23 stay 0 unless their sticky bit holds them.
- R5: A thermal warm reset (`therm_warm_n` low) sets every bypass output of both domains, whatever the mask.
- R6: When the warm reset is released, a PLL whose sticky bit is 0 leaves bypass with the same three-edge latency as in R3.
- R7: A PLL whose sticky bit is 1 stays in bypass after the warm reset ends. It leaves bypass on the rising edge after the edge at which a 0 is written to its sticky bit.
- R8: A sticky bit that is set when no warm reset has occurred does not put its PLL into bypass.
- R9: The register map, selected by `reg_addr`, is as follows. Unused high read bits are 0, and writes to the two read-only addresses change nothing.

  | `reg_addr` | Access | Contents |
  |---|---|---|
  | 0 | read/write | always-on sticky bits, bits 2:0 |
  | 1 | read/write | main sticky bits, bits 25:0 |
  | 2 | read-only | always-on bypass state |
  | 3 | read-only | main bypass state |

- R10: Warm resets never change the sticky bits.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Controller clock |
| aon_por_n | input | 1 | Always-on power-on reset, active low |
| main_por_n | input | 1 | Main-domain power-on reset, active low |
| aon_warm_n | input | 1 | Always-on warm reset pin, active low |
| req_warm_n | input | 1 | Warm reset request, active low |
| therm_warm_n | input | 1 | Thermal over-temperature warm reset, active low |
| reg_wr_en | input | 1 | Register write strobe |
| reg_addr | input | 2 | Register select |
| reg_wr_data | input | 26 | Register write data |
| reg_rd_data | output | 26 | Register read data for `reg_addr` |
| aon_pll_rst | output | 3 | Always-on PLL reset, active high |
| aon_pll_byp | output | 3 | Always-on PLL bypass select |
| main_pll_rst | output | 26 | Main PLL reset, active high |
| main_pll_byp | output | 26 | Main PLL bypass select |

## Verification
The bench drives each warm source on its own and then together:

- **Ordinary warm reset alone.** This separates the masked main subset from the unmasked indices.
- **Thermal warm reset alone.** This shows whether the mask is correctly overridden.

Sticky patterns that mix masked and unmasked indices show the difference between a hold that started from a real bypass and a sticky bit set with no warm event. A main power-on pulse is applied while the always-on PLLs are held by their sticky bits, which shows whether the two power-on domains stay independent. A random phase then mixes every reset source, register writes and reads at all four addresses.

// File: rtl/pll_rc_pkg.sv
package pll_rc_pkg;
  localparam int ADDR_W = 2;
  typedef enum logic [ADDR_W-1:0] {
    RA_AON_STICKY  = 2'd0,
    RA_MAIN_STICKY = 2'd1,
    RA_AON_STATE   = 2'd2,
    RA_MAIN_STATE  = 2'd3
  } reg_addr_e;
endpackage

// File: rtl/pll_rc_sync2.sv
module pll_rc_sync2 #(
  parameter int W = 1,
  parameter logic RST_VAL = 1'b1
) (
  input  logic         clk,
  input  logic         arst_n,
  input  logic [W-1:0] din,
  output logic [W-1:0] dout
);
  logic [W-1:0] st1_q, st2_q;

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) begin
      st1_q <= {W{RST_VAL}};
      st2_q <= {W{RST_VAL}};
    end else begin
      st1_q <= din;
      st2_q <= st1_q;
    end
  end

  assign dout = st2_q;
endmodule

// File: rtl/pll_rc_por_sync.sv
module pll_rc_por_sync (
  input  logic clk,
  input  logic arst_n,
  output logic rst_act
);
  logic [1:0] rel_q, rel_d;

  always_comb rel_d = {rel_q[0], 1'b1};

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) rel_q <= 2'b00;
    else         rel_q <= rel_d;
  end

  assign rst_act = ~rel_q[1];
endmodule

// File: rtl/pll_rc_byp_bank.sv
module pll_rc_byp_bank #(
  parameter int N = 3,
  parameter logic [N-1:0] MASK = '1
) (
  input  logic         clk,
  input  logic         arst_n,
  input  logic         ord_warm,
  input  logic         therm_warm,
  input  logic         wr_en,
  input  logic [N-1:0] wr_data,
  output logic [N-1:0] sticky,
  output logic [N-1:0] byp
);
  logic [N-1:0] warm_hit;
  logic [N-1:0] sticky_q, sticky_d;
  logic [N-1:0] byp_q, byp_d;

  for (genvar i = 0; i < N; i++) begin : g_src
    if (MASK[i]) begin : g_masked
      assign warm_hit[i] = ord_warm | therm_warm;
    end else begin : g_thermal_only
      assign warm_hit[i] = therm_warm;
    end
  end

  always_comb begin
    sticky_d = wr_en ? wr_data : sticky_q;
    byp_d    = warm_hit | (byp_q & sticky_q);
  end

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) begin
      sticky_q <= '0;
      byp_q    <= '0;
    end else begin
      sticky_q <= sticky_d;
      byp_q    <= byp_d;
    end
  end

  assign sticky = sticky_q;
  assign byp    = byp_q;

  // R5
  therm_all_byp_chk: assert property (@(posedge clk) disable iff (!arst_n)
    therm_warm |=> (&byp_q));
  // R4
  mask_only_chk: assert property (@(posedge clk) disable iff (!arst_n)
    (!therm_warm && ((byp_q & sticky_q) == '0)) |=> ((byp_q & ~MASK) == '0));
  // R7
  sticky_hold_chk: assert property (@(posedge clk) disable iff (!arst_n)
    (|(byp_q & sticky_q)) |=> (($past(byp_q & sticky_q) & ~byp_q) == '0));
  // R8
  no_spurious_byp_chk: assert property (@(posedge clk) disable iff (!arst_n)
    (!ord_warm && !therm_warm && ((byp_q & sticky_q) == '0)) |=> (byp_q == '0));
endmodule

// File: rtl/pll_rst_byp_ctrl.sv
module pll_rst_byp_ctrl
  import pll_rc_pkg::*;
#(
  parameter int AON_N  = 3,
  parameter int MAIN_N = 26,
  parameter logic [MAIN_N-1:0] MAIN_WARM_MASK = 26'h300F1F1,
  localparam int REG_W = (MAIN_N > AON_N) ? MAIN_N : AON_N
) (
  input  logic              clk,
  input  logic              aon_por_n,
  input  logic              main_por_n,
  input  logic              aon_warm_n,
  input  logic              req_warm_n,
  input  logic              therm_warm_n,
  input  logic              reg_wr_en,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic [REG_W-1:0]  reg_wr_data,
  output logic [REG_W-1:0]  reg_rd_data,
  output logic [AON_N-1:0]  aon_pll_rst,
  output logic [AON_N-1:0]  aon_pll_byp,
  output logic [MAIN_N-1:0] main_pll_rst,
  output logic [MAIN_N-1:0] main_pll_byp
);
  logic main_arst_n;
  logic aon_rst_act, main_rst_act;
  logic [2:0] warm_s;
  logic ord_warm, therm_warm;
  logic aon_we, main_we;
  logic [AON_N-1:0]  aon_sticky;
  logic [MAIN_N-1:0] main_sticky;

  assign main_arst_n = aon_por_n & main_por_n;

  pll_rc_por_sync u_aon_por (
    .clk(clk), .arst_n(aon_por_n), .rst_act(aon_rst_act));
  pll_rc_por_sync u_main_por (
    .clk(clk), .arst_n(main_arst_n), .rst_act(main_rst_act));

  pll_rc_sync2 #(.W(3), .RST_VAL(1'b1)) u_warm_sync (
    .clk(clk), .arst_n(aon_por_n),
    .din({therm_warm_n, req_warm_n, aon_warm_n}), .dout(warm_s));

  assign ord_warm   = ~warm_s[0] | ~warm_s[1];
  assign therm_warm = ~warm_s[2];

  assign aon_we  = reg_wr_en && (reg_addr == RA_AON_STICKY);
  assign main_we = reg_wr_en && (reg_addr == RA_MAIN_STICKY);

  pll_rc_byp_bank #(.N(AON_N), .MASK({AON_N{1'b1}})) u_aon_bank (
    .clk(clk), .arst_n(aon_por_n), .ord_warm(ord_warm), .therm_warm(therm_warm),
    .wr_en(aon_we), .wr_data(reg_wr_data[AON_N-1:0]),
    .sticky(aon_sticky), .byp(aon_pll_byp));

  pll_rc_byp_bank #(.N(MAIN_N), .MASK(MAIN_WARM_MASK)) u_main_bank (
    .clk(clk), .arst_n(main_arst_n), .ord_warm(ord_warm), .therm_warm(therm_warm),
    .wr_en(main_we), .wr_data(reg_wr_data[MAIN_N-1:0]),
    .sticky(main_sticky), .byp(main_pll_byp));

  assign aon_pll_rst  = {AON_N{aon_rst_act}};
  assign main_pll_rst = {MAIN_N{main_rst_act}};

  always_comb begin
    reg_rd_data = '0;
    case (reg_addr)
      RA_AON_STICKY:  reg_rd_data[AON_N-1:0]  = aon_sticky;
      RA_MAIN_STICKY: reg_rd_data[MAIN_N-1:0] = main_sticky;
      RA_AON_STATE:   reg_rd_data[AON_N-1:0]  = aon_pll_byp;
      default:        reg_rd_data[MAIN_N-1:0] = main_pll_byp;
    endcase
  end

  // R1
  aon_por_all_rst_chk: assert property (@(posedge clk)
    !aon_por_n |-> ((&aon_pll_rst) && (&main_pll_rst) && (aon_pll_byp == '0)));
  // R2
  main_por_rst_chk: assert property (@(posedge clk)
    !main_por_n |-> ((&main_pll_rst) && (main_pll_byp == '0)));
  // R3
  ord_warm_aon_chk: assert property (@(posedge clk) disable iff (!aon_por_n)
    ord_warm |=> (&aon_pll_byp));
  // R10
  warm_keeps_sticky_chk: assert property (@(posedge clk) disable iff (!main_arst_n)
    !reg_wr_en |=> ($stable(main_sticky) && $stable(aon_sticky)));
  // R9
  ro_write_ignored_chk: assert property (@(posedge clk) disable iff (!main_arst_n)
    (reg_wr_en && reg_addr[1]) |=> ($stable(main_sticky) && $stable(aon_sticky)));
endmodule

// File: tb/pll_rst_byp_ctrl_test.sv
module pll_rst_byp_ctrl_test;
  logic clk = 1'b0;
  logic aon_por_n, main_por_n, aon_warm_n, req_warm_n, therm_warm_n;
  logic reg_wr_en;
  logic [1:0] reg_addr;
  logic [25:0] reg_wr_data, reg_rd_data;
  logic [2:0] aon_pll_rst, aon_pll_byp;
  logic [25:0] main_pll_rst, main_pll_byp;

  always #10 clk = ~clk;

  pll_rst_byp_ctrl uut (
    .clk(clk), .aon_por_n(aon_por_n), .main_por_n(main_por_n),
    .aon_warm_n(aon_warm_n), .req_warm_n(req_warm_n), .therm_warm_n(therm_warm_n),
    .reg_wr_en(reg_wr_en), .reg_addr(reg_addr), .reg_wr_data(reg_wr_data),
    .reg_rd_data(reg_rd_data), .aon_pll_rst(aon_pll_rst), .aon_pll_byp(aon_pll_byp),
    .main_pll_rst(main_pll_rst), .main_pll_byp(main_pll_byp));

  int checks = 0, fails = 0, cyc = 0;
  bit done = 0;
  string cur_req = "R1";

  // reference model state
  logic [25:0] warm_list_mask;
  logic [2:0]  m_wq[$];
  logic [2:0]  m_aon_byp, m_aon_st;
  logic [25:0] m_main_byp, m_main_st;
  int m_aon_cnt, m_main_cnt;

  task automatic m_clear_aon();
    m_aon_byp = '0; m_aon_st = '0; m_aon_cnt = 0;
    m_wq = {3'b111, 3'b111, 3'b111};
  endtask
  task automatic m_clear_main();
    m_main_byp = '0; m_main_st = '0; m_main_cnt = 0;
  endtask
  task automatic m_async();
    if (!aon_por_n) begin m_clear_aon(); m_clear_main(); end
    else if (!main_por_n) m_clear_main();
  endtask

  initial begin
    int idx[12] = '{0, 4, 5, 6, 7, 8, 12, 13, 14, 15, 24, 25};
    warm_list_mask = '0;
    foreach (idx[k]) warm_list_mask[idx[k]] = 1'b1;
    m_clear_aon(); m_clear_main();
  end

  always @(posedge clk) begin
    logic [2:0] w;
    bit ordw, thw;
    logic [2:0] old_ast;
    logic [25:0] old_mst;
    cyc++;
    if (!aon_por_n) begin
      m_clear_aon(); m_clear_main();
    end else begin
      m_wq.push_front({therm_warm_n, req_warm_n, aon_warm_n});
      w = m_wq[2];
      void'(m_wq.pop_back());
      ordw = !w[0] || !w[1];
      thw  = !w[2];
      old_ast = m_aon_st; old_mst = m_main_st;
      if (m_aon_cnt < 2) m_aon_cnt++;
      m_aon_byp = ((ordw || thw) ? 3'b111 : 3'b000) | (m_aon_byp & old_ast);
      if (reg_wr_en && reg_addr == 2'd0) m_aon_st = reg_wr_data[2:0];
      if (!main_por_n) m_clear_main();
      else begin
        if (m_main_cnt < 2) m_main_cnt++;
        m_main_byp = (thw ? '1 : (ordw ? warm_list_mask : '0)) | (m_main_byp & old_mst);
        if (reg_wr_en && reg_addr == 2'd1) m_main_st = reg_wr_data;
      end
    end
  end

  task automatic chk(string what, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s: actual %h expected %h (t=%0t)", cur_req, what, act, exp, $time);
    end
  endtask

  always @(negedge clk) begin
    logic [25:0] erd;
    if (!done) begin
      m_async();
      case (reg_addr)
        2'd0: erd = {23'd0, m_aon_st};
        2'd1: erd = m_main_st;
        2'd2: erd = {23'd0, m_aon_byp};
        default: erd = m_main_byp;
      endcase
      chk("aon_rst",  {29'd0, aon_pll_rst},  {29'd0, {3{m_aon_cnt < 2}}});
      chk("main_rst", {6'd0, main_pll_rst}, {6'd0, {26{m_main_cnt < 2}}});
      chk("aon_byp",  {29'd0, aon_pll_byp},  {29'd0, m_aon_byp});
      chk("main_byp", {6'd0, main_pll_byp}, {6'd0, m_main_byp});
      chk("rd_data",  {6'd0, reg_rd_data},  {6'd0, erd});
    end
  end

  task automatic tick(int n);
    repeat (n) @(posedge clk);
    #5;
  endtask

  task automatic wr(logic [1:0] a, logic [25:0] d);
    reg_wr_en = 1'b1; reg_addr = a; reg_wr_data = d;
    tick(1);
    reg_wr_en = 1'b0;
  endtask

  initial begin
    aon_por_n = 0; main_por_n = 0; aon_warm_n = 1; req_warm_n = 1; therm_warm_n = 1;
    reg_wr_en = 0; reg_addr = 0; reg_wr_data = '0;
    // R1: reset state and release timing
    cur_req = "R1";
    tick(4);
    aon_por_n = 1; tick(1); main_por_n = 1; tick(4);
    // R9: register map, read-only writes ignored
    cur_req = "R9";
    wr(2'd0, 26'h3FFFFFA); reg_addr = 2'd0; tick(1);
    wr(2'd1, 26'h0A5A5A5); reg_addr = 2'd1; tick(1);
    wr(2'd2, 26'h3FFFFFF); reg_addr = 2'd0; tick(1);
    wr(2'd3, 26'h3FFFFFF); reg_addr = 2'd1; tick(1);
    wr(2'd0, 26'd0); wr(2'd1, 26'd0);
    // R3 / R4: ordinary warm via pin
    cur_req = "R3"; reg_addr = 2'd2;
    aon_warm_n = 0; tick(6);
    cur_req = "R4"; reg_addr = 2'd3; tick(2);
    cur_req = "R6"; aon_warm_n = 1; tick(5);
    cur_req = "R4"; req_warm_n = 0; tick(6);
    cur_req = "R6"; req_warm_n = 1; tick(5);
    // R5: thermal bypasses all
    cur_req = "R5"; therm_warm_n = 0; tick(6);
    cur_req = "R6"; therm_warm_n = 1; tick(5);
    // R7: sticky hold after warm, cleared by software
    cur_req = "R7";
    wr(2'd0, 26'h5); wr(2'd1, 26'h00F000F);
    aon_warm_n = 0; tick(5);
    cur_req = "R10"; reg_addr = 2'd1; tick(2);
    aon_warm_n = 1; cur_req = "R7"; reg_addr = 2'd3; tick(8);
    therm_warm_n = 0; tick(4); therm_warm_n = 1; tick(6);
    // R2: main power-on while always-on PLLs held
    cur_req = "R2"; reg_addr = 2'd2;
    main_por_n = 0; tick(4); reg_addr = 2'd1; tick(2); main_por_n = 1; tick(5);
    cur_req = "R7";
    wr(2'd0, 26'h1); reg_addr = 2'd2; tick(3);
    wr(2'd0, 26'h0); tick(3);
    // R8: sticky with no warm event
    cur_req = "R8";
    wr(2'd0, 26'h7); wr(2'd1, 26'h3FFFFFF); reg_addr = 2'd3; tick(8);
    // R1: power-on mid-operation
    cur_req = "R1";
    req_warm_n = 0; tick(5); aon_por_n = 0; #3; tick(3);
    aon_por_n = 1; req_warm_n = 1; tick(6);
    // random mix
    cur_req = "R10";
    for (int i = 0; i < 600; i++) begin
      int r;
      r = $urandom_range(0, 99);
      aon_warm_n   = (r < 8)  ? 1'b0 : (r < 30 ? aon_warm_n : 1'b1);
      req_warm_n   = ($urandom_range(0, 9) == 0) ? ~req_warm_n : req_warm_n;
      therm_warm_n = ($urandom_range(0, 19) == 0) ? ~therm_warm_n : therm_warm_n;
      main_por_n   = ($urandom_range(0, 99) < 2) ? 1'b0 : 1'b1;
      aon_por_n    = ($urandom_range(0, 299) == 0) ? 1'b0 : 1'b1;
      reg_addr     = 2'($urandom_range(0, 3));
      reg_wr_en    = ($urandom_range(0, 9) == 0);
      reg_wr_data  = 26'($urandom());
      tick(1);
    end
    reg_wr_en = 0; aon_por_n = 1; main_por_n = 1;
    aon_warm_n = 1; req_warm_n = 1; therm_warm_n = 1;
    tick(6);
    done = 1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  always @(posedge clk) begin
    if (cyc > 20000 && !done) begin
      done = 1;
      checks++; fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end
endmodule